// File: doc/BRIEF.md
# Paged Logical-to-Physical Address Translator

This block turns a short logical address into a physical byte address using a small page table that belongs to the running process. The high bits of the logical address pick one table entry. The low bits give a position inside the page, counted in 32-bit words. Each entry stores a frame number and a flag that says whether the mapping exists.

Frames are 1000 bytes long, which is not a power of two. A physical address therefore cannot be formed by joining the frame and offset bits. It is computed as frame × 1000 + word offset × 4. The multiply by 1000 uses fixed shifts and subtractions, so no multiplier is needed.

Software fills the table through a single-entry write port. A lookup is presented together with a request strobe, and the result appears one clock later. The result is either a physical address, or a fault when the selected page has no valid mapping.

Top module: `pt_xlate`

## Requirements
- R1: After a synchronous active-high reset, resp_valid, resp_fault and resp_paddr are all 0, and every table entry is invalid, so any lookup faults until a valid entry is written.
- R2: resp_valid is high in exactly the cycle after a cycle in which req_valid was high, and low otherwise.
- R3: The page index is req_laddr[3:2] and the word offset is req_laddr[1:0].
- R4: For a lookup to a valid page, resp_fault is 0 and resp_paddr equals frame × 1000 + offset × 4.
- R5: For a lookup to a page whose entry is invalid, resp_fault is 1 and resp_paddr is 0.
- R6: When wr_en is high at a clock edge, the entry wr_page takes wr_frame and wr_valid. Writing wr_valid = 0 removes a mapping, and later lookups to that page fault.
- R7: A write and a lookup to the same page in the same cycle return the entry as it stood before the write. The new entry applies to lookups from the next cycle on.
- R8: When resp_valid is low, resp_fault and resp_paddr are both 0.
- R9: The largest address, frame 255 with offset 3, gives 255012 with no truncation in the 18-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 2 | Index of the entry to write |
| wr_frame | input | 8 | Frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| req_valid | input | 1 | Lookup request strobe |
| req_laddr | input | 4 | Logical address to translate |
| resp_valid | output | 1 | Result valid, one cycle after the request |
| resp_fault | output | 1 | Selected page has no valid mapping |
| resp_paddr | output | 18 | Physical byte address, or 0 on a fault |

## Verification
On every cycle, the assertions check the following:
- the one-cycle link between request and response;
- that faulted and idle responses carry a zero address;
- that a translated address is word aligned, and its position within its frame matches the offset bits of the request.

Some behaviours depend on what the table holds, so only the bench's scenarios can show them:
- the exact frame term;
- the read-before-write result of a write and a lookup in the same cycle;
- the removal of a mapping by a write with the valid flag clear;
- the reset-cleared table.

The bench shows these by checking each response against its own model of the table.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef struct packed {
    logic       ok;
    logic [7:0] frame;
  } pt_entry_t;
endpackage

// File: rtl/pt_table.sv
module pt_table #(
  parameter int PAGE_BITS  = 2,
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PAGE_BITS-1:0]  wr_page,
  input  logic [FRAME_BITS-1:0] wr_frame,
  input  logic                  wr_valid,
  input  logic [PAGE_BITS-1:0]  rd_page,
  output logic [FRAME_BITS-1:0] rd_frame,
  output logic                  rd_ok
);
  localparam int PAGES = 1 << PAGE_BITS;

  // frame storage carries no reset so it maps onto distributed RAM
  logic [FRAME_BITS-1:0] frame_mem [PAGES];
  logic [PAGES-1:0]      ok_bits;

  always_ff @(posedge clk) begin
    if (wr_en) frame_mem[wr_page] <= wr_frame;
  end

  for (genvar g = 0; g < PAGES; g++) begin : g_ok
    always_ff @(posedge clk) begin
      if (rst)                                     ok_bits[g] <= 1'b0;
      else if (wr_en && wr_page == PAGE_BITS'(g))  ok_bits[g] <= wr_valid;
    end
  end

  // read is asynchronous: the caller registers the result, so a same-cycle
  // write is seen only from the following cycle
  assign rd_frame = frame_mem[rd_page];
  assign rd_ok    = ok_bits[rd_page];
endmodule

// File: rtl/pt_frame_scale.sv
module pt_frame_scale #(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_BYTES = 1000,
  parameter int PADDR_BITS  = 18
) (
  input  logic [FRAME_BITS-1:0] frame,
  output logic [PADDR_BITS-1:0] base
);
  logic [PADDR_BITS-1:0] f_ext;
  assign f_ext = PADDR_BITS'(frame);

  if (FRAME_BYTES == 1000) begin : g_shift_add
    // 1000 = 1024 - 16 - 8; the arithmetic wraps, but the final value fits
    assign base = (f_ext << 10) - (f_ext << 4) - (f_ext << 3);
  end else begin : g_generic
    assign base = PADDR_BITS'(f_ext * PADDR_BITS'(FRAME_BYTES));
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int PAGE_BITS   = 2,
  parameter int OFFSET_BITS = 2,
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_BYTES = 1000,
  parameter int WORD_BYTES  = 4,
  parameter int PADDR_BITS  = 18
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [PAGE_BITS-1:0]             wr_page,
  input  logic [FRAME_BITS-1:0]            wr_frame,
  input  logic                             wr_valid,
  input  logic                             req_valid,
  input  logic [PAGE_BITS+OFFSET_BITS-1:0] req_laddr,
  output logic                             resp_valid,
  output logic                             resp_fault,
  output logic [PADDR_BITS-1:0]            resp_paddr
);
  import pt_pkg::*;

  localparam int LADDR_BITS = PAGE_BITS + OFFSET_BITS;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);

  logic [PAGE_BITS-1:0]   page_sel;
  logic [OFFSET_BITS-1:0] word_off;
  pt_entry_t              entry;
  logic [PADDR_BITS-1:0]  frame_base;
  logic [PADDR_BITS-1:0]  byte_off;
  logic [PADDR_BITS-1:0]  paddr_next;

  assign page_sel = req_laddr[LADDR_BITS-1:OFFSET_BITS];
  assign word_off = req_laddr[OFFSET_BITS-1:0];

  pt_table #(
    .PAGE_BITS (PAGE_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) i_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_page (wr_page),
    .wr_frame(wr_frame),
    .wr_valid(wr_valid),
    .rd_page (page_sel),
    .rd_frame(entry.frame),
    .rd_ok   (entry.ok)
  );

  pt_frame_scale #(
    .FRAME_BITS (FRAME_BITS),
    .FRAME_BYTES(FRAME_BYTES),
    .PADDR_BITS (PADDR_BITS)
  ) i_scale (
    .frame(entry.frame),
    .base (frame_base)
  );

  assign byte_off   = PADDR_BITS'(word_off) << WORD_SHIFT;
  assign paddr_next = frame_base + byte_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_fault <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_fault <= req_valid & ~entry.ok;
      resp_paddr <= (req_valid && entry.ok) ? paddr_next : '0;
    end
  end
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int PAGE_BITS   = 2,
  parameter int OFFSET_BITS = 2,
  parameter int FRAME_BYTES = 1000,
  parameter int WORD_BYTES  = 4,
  parameter int PADDR_BITS  = 18
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             req_valid,
  input logic [PAGE_BITS+OFFSET_BITS-1:0] req_laddr,
  input logic                             resp_valid,
  input logic                             resp_fault,
  input logic [PADDR_BITS-1:0]            resp_paddr
);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);

  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> (resp_paddr == '0) && resp_valid);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !resp_fault && (resp_paddr == '0));

  // R3
  offset_match_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_fault ||
      ((32'(resp_paddr) % FRAME_BYTES) / WORD_BYTES ==
       32'($past(req_laddr[OFFSET_BITS-1:0]))));

  // R4
  word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_fault) |-> (32'(resp_paddr) % WORD_BYTES == 0));
endmodule

bind pt_xlate pt_xlate_chk #(
  .PAGE_BITS  (PAGE_BITS),
  .OFFSET_BITS(OFFSET_BITS),
  .FRAME_BYTES(FRAME_BYTES),
  .WORD_BYTES (WORD_BYTES),
  .PADDR_BITS (PADDR_BITS)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_laddr (req_laddr),
  .resp_valid(resp_valid),
  .resp_fault(resp_fault),
  .resp_paddr(resp_paddr)
);

// File: tb/test_pt_xlate.sv
module test_pt_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_page;
  logic [7:0]  wr_frame;
  logic        wr_valid;
  logic        req_valid;
  logic [3:0]  req_laddr;
  logic        resp_valid;
  logic        resp_fault;
  logic [17:0] resp_paddr;

  int checks = 0;
  int errors = 0;
  bit m_ok [4];
  int m_frame [4];

  always #2 clk = ~clk;

  pt_xlate i_pt_xlate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_page(wr_page),
    .wr_frame(wr_frame), .wr_valid(wr_valid), .req_valid(req_valid),
    .req_laddr(req_laddr), .resp_valid(resp_valid),
    .resp_fault(resp_fault), .resp_paddr(resp_paddr)
  );

  function automatic int exp_addr(int frame, int off);
    return frame * 1000 + off * 4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict from the pre-edge table, check after edge
  task automatic step(bit we, int wp, int wf, bit wv, bit rq, int la, string req);
    bit e_fault;
    int e_addr;
    @(negedge clk);
    wr_en = we; wr_page = 2'(wp); wr_frame = 8'(wf); wr_valid = wv;
    req_valid = rq; req_laddr = 4'(la);
    e_fault = rq && !m_ok[la >> 2];
    e_addr  = (rq && m_ok[la >> 2]) ? exp_addr(m_frame[la >> 2], la & 3) : 0;
    @(posedge clk);
    #1;
    if (we) begin m_ok[wp] = wv; m_frame[wp] = wf; end
    check({req, " valid"}, int'(resp_valid), int'(rq));
    check({req, " fault"}, int'(resp_fault), int'(e_fault));
    check({req, " paddr"}, int'(resp_paddr), e_addr);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4; i++) begin m_ok[i] = 0; m_frame[i] = 0; end
    rst = 1; wr_en = 0; wr_page = 0; wr_frame = 0; wr_valid = 0;
    req_valid = 0; req_laddr = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset valid", int'(resp_valid), 0);
    check("R1 reset fault", int'(resp_fault), 0);
    check("R1 reset paddr", int'(resp_paddr), 0);
    @(negedge clk); rst = 0;
    // R1 table cleared: every page faults
    for (int p = 0; p < 4; p++) step(0, 0, 0, 0, 1, p * 4 + 1, "R1 R5 empty");
    // R8 idle cycle
    step(0, 0, 0, 0, 0, 0, "R8 idle");
    // R4 R3 worked example: page 3 to frame 55, logical 0b1101 -> 55004
    step(1, 3, 55, 1, 0, 0, "R6 write");
    step(0, 0, 0, 0, 1, 4'b1101, "R4 R3 example");
    check("R4 example value", int'(resp_paddr), 55004);
    // R9 largest address
    step(1, 1, 255, 1, 0, 0, "R6 write");
    step(0, 0, 0, 0, 1, 4'b0111, "R9 max");
    check("R9 max value", int'(resp_paddr), 255012);
    // R7 same-cycle write and lookup returns old entry, then new
    step(1, 3, 12, 1, 1, 4'b1110, "R7 old entry");
    step(0, 0, 0, 0, 1, 4'b1110, "R7 new entry");
    step(1, 2, 7, 1, 1, 4'b1000, "R7 old invalid");
    // R6 clearing a mapping
    step(1, 3, 99, 0, 0, 0, "R6 invalidate");
    step(0, 0, 0, 0, 1, 4'b1100, "R6 R5 removed");
    // R2 back-to-back requests across all offsets
    for (int o = 0; o < 4; o++) step(0, 0, 0, 0, 1, 8 + o, "R2 R3 burst");
    // random mix
    for (int i = 0; i < 400; i++) begin
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), bit'($urandom_range(0, 3) != 0),
           bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 15)),
           "R4 R5 R6 random");
    end
    // R1 reset in mid-run clears the table again
    @(negedge clk); rst = 1; wr_en = 0; req_valid = 0;
    @(posedge clk); #1;
    check("R1 reset valid", int'(resp_valid), 0);
    @(negedge clk); rst = 0;
    for (int p = 0; p < 4; p++) m_ok[p] = 0;
    for (int p = 0; p < 4; p++) step(0, 0, 0, 0, 1, p * 4, "R1 cleared");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule